// File: doc/BRIEF.md
# Command Stream Length Validator

This block sits in the path of a command buffer that is made of 32-bit dwords. It reads each instruction header and works out how many dwords the instruction covers, header included. It forwards the header and its payload unchanged. If a header is illegal, or if the instruction would run past the end of the buffer, the whole buffer is refused. Before the buffer starts, the user gives the buffer's total dword count and pulses `start_i`. The dwords then arrive on a valid/ready input. Accepted dwords leave on a valid/ready output in the same cycle, with no storage between the two sides.

A header carries a client field in its top three bits. Below that sit opcode fields whose meaning depends on the client, and these fields give the length. A decoded length of zero marks the command as illegal. If the buffer ends cleanly and its dword count is odd, the block sends one extra zero dword so that the output count is even. A refused buffer ends in a latched error state: the offending header is not taken, and no further dwords are taken or sent. Dwords already sent stay sent.

Top module: `cmd_len_gate`

## Requirements
- R1: With client field bits 31:29 = 0, only sub-opcode bits 28:23 = 0x00 or 0x04 are legal, and each is 1 dword long. Any other sub-opcode is illegal.
- R2: Client values 1, 4, 5, 6 and 7 are always illegal.
- R3: With client 2, the length is bits 7:0 plus 2.
- R4: With client 3, opcode bits 28:24 with a value of 0x18 or less, or equal to 0x1c, give length 1. Opcodes 0x19 to 0x1b are illegal.
- R5: With client 3 and opcode 0x1d, bits 23:16 choose the length field. A value of 3 gives bits 4:0 plus 2, a value of 4 gives bits 3:0 plus 2, and any other value gives bits 15:0 plus 2.
- R6: With client 3 and opcode 0x1e, bit 23 set gives bits 15:0 plus 1. Bit 23 clear gives length 1.
- R7: With client 3 and opcode 0x1f, the length depends on bits 23 and 17:
  - bit 23 clear gives bits 16:0 plus 2;
  - bit 23 set and bit 17 clear gives 2;
  - both bits set gives ((bits 15:0 + 1) / 2) + 1, and this case is illegal when bits 15:0 are zero.
- R8: A header whose position plus length exceeds the total count aborts the buffer. So does an illegal header.
- R9: After a clean end with an odd total, exactly one zero dword is sent before done. With an even total, no extra dword is sent.
- R10: When a buffer aborts, error_o latches and no dword is taken or sent afterwards. Earlier output is kept. done_o and error_o are never high together, and both hold until the next accepted start.
- R11: A dword is taken from the input only in the same cycle as it is sent, with equal data. An illegal header raises the error even while out_ready_i is low.
- R12: A total of zero ends in done at once, with no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a buffer; taken only when not busy |
| total_i | input | CNT_W | Dword count of the buffer, latched on start |
| in_valid_i | input | 1 | Input dword valid |
| in_data_i | input | 32 | Input dword |
| in_ready_o | output | 1 | Input dword taken |
| out_valid_o | output | 1 | Output dword valid |
| out_data_o | output | 32 | Output dword (zero while padding) |
| out_ready_i | input | 1 | Downstream accepts |
| busy_o | output | 1 | Buffer in progress |
| done_o | output | 1 | Buffer finished cleanly |
| error_o | output | 1 | Buffer aborted |

## Verification
Two functions can act in the same cycle: the header legality check and output backpressure. The bench shows an illegal first header while holding out_ready_i low, and expects the error with no transfer. The end-of-buffer decision and the padding decision also meet: the last payload dword of an odd buffer must be followed by exactly one zero dword. The bench builds buffers of odd and even size under random stalls. It also builds headers whose length reaches exactly to the end, and others that pass it by one. A behavioural model compares every output transfer and the final flags.

// File: rtl/cmd_len_pkg.sv
package cmd_len_pkg;
  localparam int DW    = 32;
  localparam int LEN_W = 18;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_PAD  = 3'd2,
    ST_DONE = 3'd3,
    ST_ERR  = 3'd4
  } gate_st_e;
endpackage

// File: rtl/cmd_len_decode.sv
module cmd_len_decode
  import cmd_len_pkg::*;
(
  input  logic [DW-1:0]    hdr_i,
  output logic [LEN_W-1:0] len_o
);
  logic [2:0]  client;
  logic [5:0]  sub_op;
  logic [4:0]  op3;
  logic [7:0]  sel;
  logic [16:0] half_sum;

  assign client   = hdr_i[31:29];
  assign sub_op   = hdr_i[28:23];
  assign op3      = hdr_i[28:24];
  assign sel      = hdr_i[23:16];
  assign half_sum = {1'b0, hdr_i[15:0]} + 17'd1;

  always_comb begin
    len_o = '0;
    unique case (client)
      3'd0: if (sub_op == 6'h00 || sub_op == 6'h04) len_o = LEN_W'(1);
      3'd2: len_o = LEN_W'(hdr_i[7:0]) + LEN_W'(2);
      3'd3: begin
        if (op3 <= 5'h18 || op3 == 5'h1c) begin
          len_o = LEN_W'(1);
        end else if (op3 == 5'h1d) begin
          if (sel == 8'd3)      len_o = LEN_W'(hdr_i[4:0])  + LEN_W'(2);
          else if (sel == 8'd4) len_o = LEN_W'(hdr_i[3:0])  + LEN_W'(2);
          else                  len_o = LEN_W'(hdr_i[15:0]) + LEN_W'(2);
        end else if (op3 == 5'h1e) begin
          len_o = hdr_i[23] ? LEN_W'(hdr_i[15:0]) + LEN_W'(1) : LEN_W'(1);
        end else if (op3 == 5'h1f) begin
          if (!hdr_i[23])                len_o = LEN_W'(hdr_i[16:0]) + LEN_W'(2);
          else if (!hdr_i[17])           len_o = LEN_W'(2);
          else if (hdr_i[15:0] != 16'h0) len_o = LEN_W'(half_sum[16:1]) + LEN_W'(1);
          else                           len_o = '0;
        end
      end
      default: len_o = '0;
    endcase
  end
endmodule

// File: rtl/cmd_len_gate.sv
module cmd_len_gate
  import cmd_len_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             in_valid_i,
  input  logic [DW-1:0]    in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [DW-1:0]    out_data_o,
  input  logic             out_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o
);
  localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1;

  gate_st_e         st_q;
  logic [CNT_W-1:0] pos_q, total_q;
  logic [LEN_W-1:0] rem_q, hdr_len;
  logic [SUM_W-1:0] end_pos;
  logic             at_hdr, hdr_ok, pass_ok, run, fire, abort_ev, last_dw;

  cmd_len_decode u_dec (.hdr_i(in_data_i), .len_o(hdr_len));

  assign at_hdr   = (rem_q == '0);
  assign end_pos  = SUM_W'(pos_q) + SUM_W'(hdr_len);
  assign hdr_ok   = (hdr_len != '0) && (end_pos <= SUM_W'(total_q));
  assign pass_ok  = !at_hdr || hdr_ok;
  assign run      = (st_q == ST_RUN);
  assign last_dw  = (SUM_W'(pos_q) + SUM_W'(1)) == SUM_W'(total_q);

  assign out_valid_o = (run && in_valid_i && pass_ok) || (st_q == ST_PAD);
  assign out_data_o  = (st_q == ST_PAD) ? '0 : in_data_i;
  assign in_ready_o  = run && pass_ok && out_ready_i;
  assign fire        = in_valid_i && in_ready_o;
  // legality is judged without waiting for downstream
  assign abort_ev    = run && in_valid_i && !pass_ok;

  assign busy_o  = run || (st_q == ST_PAD);
  assign done_o  = (st_q == ST_DONE);
  assign error_o = (st_q == ST_ERR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pos_q   <= '0;
      rem_q   <= '0;
      total_q <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (abort_ev) begin
            st_q <= ST_ERR;
          end else if (fire) begin
            pos_q <= pos_q + CNT_W'(1);
            rem_q <= at_hdr ? hdr_len - LEN_W'(1) : rem_q - LEN_W'(1);
            if (last_dw) st_q <= total_q[0] ? ST_PAD : ST_DONE;
          end
        end
        ST_PAD: if (out_ready_i) st_q <= ST_DONE;
        default: begin
          if (start_i) begin
            total_q <= total_i;
            pos_q   <= '0;
            rem_q   <= '0;
            st_q    <= (total_i == '0) ? ST_DONE : ST_RUN;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cmd_len_gate_chk.sv
module cmd_len_gate_chk
  import cmd_len_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          in_valid_i,
  input logic [DW-1:0] in_data_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic [DW-1:0] out_data_o,
  input logic          out_ready_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          error_o,
  input logic          at_hdr
);
  logic [CNT_W:0] sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sent_q <= '0;
    else if (start_i && !busy_o)  sent_q <= '0;
    else if (out_valid_o && out_ready_i) sent_q <= sent_q + 1'b1;
  end

  a_r11_take_is_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |-> out_valid_o && out_ready_i && out_data_o == in_data_i);

  a_r10_quiet_on_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !out_valid_o && !in_ready_o);

  a_r10_error_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o && !start_i |=> error_o);

  a_r10_flags_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  a_r9_even_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> sent_q[0] == 1'b0);

  a_r2_bad_client: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && at_hdr && (in_data_i[31:29] == 3'd1 || in_data_i[31]) |-> !in_ready_o);

  a_r1_client0_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && at_hdr && in_data_i[31:29] == 3'd0 &&
    in_data_i[28:23] != 6'h00 && in_data_i[28:23] != 6'h04 |-> !in_ready_o);
endmodule

bind cmd_len_gate cmd_len_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
  .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .at_hdr(at_hdr)
);

// File: tb/tb_cmd_len_gate.sv
module tb_cmd_len_gate;
  localparam int  CNT_W = 16;
  localparam time T_CLK = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] total = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, busy, done, err;
  logic [31:0] out_data;

  int n_chk = 0, n_fail = 0;
  logic [31:0] stim_q[$];

  always #(T_CLK/2) clk = ~clk;

  cmd_len_gate #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .total_i(total),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
    .busy_o(busy), .done_o(done), .error_o(err)
  );

  function automatic int ref_len(logic [31:0] h);
    int cl = int'(h[31:29]);
    int op = int'(h[28:24]);
    if (cl == 0) return (h[28:23] == 6'd0 || h[28:23] == 6'd4) ? 1 : 0;
    if (cl == 2) return int'(h[7:0]) + 2;
    if (cl != 3) return 0;
    if (op <= 24 || op == 28) return 1;
    if (op == 29) begin
      if (h[23:16] == 8'd3) return int'(h[4:0]) + 2;
      if (h[23:16] == 8'd4) return int'(h[3:0]) + 2;
      return int'(h[15:0]) + 2;
    end
    if (op == 30) return h[23] ? int'(h[15:0]) + 1 : 1;
    if (op == 31) begin
      if (!h[23]) return int'(h[16:0]) + 2;
      if (!h[17]) return 2;
      if (h[15:0] == 16'd0) return 0;
      return (int'(h[15:0]) + 1) / 2 + 1;
    end
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic add_cmd(logic [31:0] h);
    int l = ref_len(h);
    stim_q.push_back(h);
    for (int k = 1; k < l; k++) stim_q.push_back($urandom);
  endtask

  // stall: 0 = always ready, 1 = random, 2 = never ready
  task automatic run_buf(int tot, int stall, string tag);
    logic [31:0] exp_q[$];
    bit exp_err = 0;
    int pos = 0, idx = 0;
    while (pos < tot) begin
      int l = (pos < stim_q.size()) ? ref_len(stim_q[pos]) : 0;
      if (l == 0 || pos + l > tot) begin exp_err = 1; break; end
      for (int k = 0; k < l; k++) exp_q.push_back(stim_q[pos + k]);
      pos += l;
    end
    if (!exp_err && tot[0]) exp_q.push_back(32'h0);

    @(negedge clk);
    start = 1'b1; total = CNT_W'(tot); in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (done || err) break;
      out_ready = (stall == 0) ? 1'b1 : (stall == 1) ? ($urandom % 3 != 0) : 1'b0;
      in_valid  = idx < stim_q.size();
      in_data   = in_valid ? stim_q[idx] : 32'h0;
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, {tag, " extra dword"}, out_data, 32'hx);
        else begin
          chk(out_data == exp_q[0], {tag, " data"}, out_data, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
      if (in_valid && in_ready) idx++;
      @(negedge clk);
    end
    chk(exp_q.size() == 0, {tag, " missing dwords"}, exp_q.size(), 0);
    chk(err == exp_err, {tag, " error flag"}, err, exp_err);
    chk(done == !exp_err, {tag, " done flag"}, done, !exp_err);
    if (exp_err) begin
      // R10: nothing moves after abort even with input offered
      in_valid = 1'b1; out_ready = 1'b1; in_data = 32'h0;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk); #1;
        chk(!out_valid && !in_ready && err, {tag, " R10 quiet"}, {out_valid, in_ready, err}, 3'b001);
      end
    end
    in_valid = 1'b0;
    stim_q.delete();
  endtask

  initial begin
    #(T_CLK * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] legal[13] = '{32'h0000_0000, 32'h0200_0000, 32'h4000_0002, 32'h7800_0000,
      32'h7C00_0000, 32'h7D03_001F, 32'h7D04_000F, 32'h7D07_0004, 32'h7E80_0003,
      32'h7E00_0000, 32'h7F00_0003, 32'h7FA2_0006, 32'h7F80_0000};
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !err && !out_valid && !in_ready, "reset state",
        {busy, done, err, out_valid, in_ready}, 0);
    rst_n = 1'b1;

    // R1
    add_cmd(32'h0000_0000); add_cmd(32'h0200_0000); run_buf(2, 0, "R1 legal client0");
    add_cmd(32'h0000_0000); stim_q.push_back(32'h0080_0000); run_buf(2, 0, "R1 illegal sub-opcode");
    // R2
    stim_q.push_back(32'h2000_0000); run_buf(1, 0, "R2 client1");
    add_cmd(32'h4000_0000); stim_q.push_back(32'hA000_0000); run_buf(3, 1, "R2 client5");
    // R3 + R9 odd pad
    add_cmd(32'h4000_0003); run_buf(5, 1, "R3 client2 len5 R9 pad");
    // R4
    add_cmd(32'h7800_0000); add_cmd(32'h7C00_0000); run_buf(2, 0, "R4 short opcodes");
    stim_q.push_back(32'h7900_0000); run_buf(1, 0, "R4 opcode 0x19");
    // R5
    add_cmd(32'h7D03_0021); add_cmd(32'h7D04_0012); add_cmd(32'h7D07_0002);
    run_buf(stim_q.size(), 1, "R5 select variants");
    // R6
    add_cmd(32'h7E80_0002); add_cmd(32'h7E00_0005); run_buf(stim_q.size(), 1, "R6 bit23 both");
    // R7
    add_cmd(32'h7F00_0001); add_cmd(32'h7FA2_0003); add_cmd(32'h7F80_0000);
    run_buf(stim_q.size(), 1, "R7 three forms");
    add_cmd(32'h0000_0000); stim_q.push_back(32'h7FA2_0000); run_buf(2, 0, "R7 zero count");
    // R8
    stim_q = '{32'h4000_0005, 32'h1, 32'h2, 32'h3}; run_buf(4, 0, "R8 overrun first");
    stim_q = '{32'h0000_0000, 32'h4000_0001, 32'h5}; run_buf(3, 1, "R8 overrun by one");
    add_cmd(32'h4000_0001); run_buf(3, 0, "R8 exact fit R9 pad");
    // R11 illegal header under backpressure
    stim_q.push_back(32'hE000_0000); run_buf(1, 2, "R11 error while stalled");
    // R12
    run_buf(0, 0, "R12 empty buffer");
    // random legal buffers, odd and even
    for (int t = 0; t < 20; t++) begin
      int n = 1 + ($urandom % 6);
      for (int c = 0; c < n; c++) add_cmd(legal[$urandom % 13]);
      run_buf(stim_q.size(), 1, "R9 R11 random buffer");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule